// File: doc/BRIEF.md
# Dirty scanline run coalescer

This block turns a per-row dirty indication into a short list of screen rectangles to repaint. Once started, it steps through the rows of the active frame at one row per cycle. It presents the current row index to an external dirty-tracking store and reads back one dirty bit for that row. Consecutive dirty rows are merged into a single rectangle. Each rectangle is handed on over a valid/ready channel as a top row and a row count, with a left column of zero and the full frame width.

A full-repaint request sampled with the start pulse, typically raised after a display mode change, skips the row walk. The block then emits one rectangle that covers the whole frame. A start that arrives while the mode is flagged invalid, or while the frame height is zero, produces no rectangle, only the completion pulse. The completion pulse is the handshake the surrounding logic uses to clear its dirty store. It is raised after the last rectangle has been accepted, and a start that arrives while a walk is in progress is ignored.

Top module: `dirty_run_coalescer`

## Requirements
- R1: After synchronous reset, `rgn_valid_o`, `busy_o` and `done_o` are all low.
- R2: During a walk, a run opens at the first dirty row seen while no run is open. The next clean row closes it and emits top row = start row and count = clean row index minus start row. Rows at or beyond the frame height are never visited.
- R3: A run that is still open after the last row (height-1) is emitted with count = height minus start row, so it ends at the frame bottom.
- R4: When `full_i` is high with an accepted start and a valid mode, exactly one rectangle with top row 0 and count = height is emitted, and no row is walked.
- R5: Every rectangle has `rgn_x_o` = 0 and `rgn_w_o` = the `width_i` value sampled with the accepted start.
- R6: A start with `mode_ok_i` low or `height_i` = 0 emits no rectangle, even with `full_i` high, and still produces one `done_o` pulse.
- R7: While `rgn_valid_o` is high and `rgn_ready_i` is low, the rectangle outputs hold their values and the walk does not advance, so no dirty row is lost.
- R8: `done_o` is a single-cycle pulse, raised once per accepted start, and only after the last rectangle has been accepted (`rgn_valid_o` low).
- R9: `start_i` is ignored while `busy_o` is high: it neither changes the frame being walked nor starts a second walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted only when idle |
| full_i | input | 1 | Full-repaint request, sampled with start |
| mode_ok_i | input | 1 | Current display mode is valid, sampled with start |
| height_i | input | ROW_W | Frame height in rows, sampled with start |
| width_i | input | COL_W | Frame width in pixels, sampled with start |
| scan_row_o | output | ROW_W | Row whose dirty bit is being consumed |
| dirty_i | input | 1 | Dirty bit for `scan_row_o`, same cycle |
| rgn_valid_o | output | 1 | Rectangle available |
| rgn_ready_i | input | 1 | Consumer accepts the rectangle |
| rgn_x_o | output | COL_W | Rectangle left column (always 0) |
| rgn_y_o | output | ROW_W | Rectangle top row |
| rgn_w_o | output | COL_W | Rectangle width (frame width) |
| rgn_h_o | output | ROW_W | Rectangle row count |
| busy_o | output | 1 | A walk or drain is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at runs that touch the frame edges: a dirty row 0, a dirty last row that must be flushed, a one-row frame, and dirty bits above the height that must not leak into a rectangle. A design that drops the end-of-walk flush loses the bottom run. One that counts off by one reports rectangles a row too tall or too short. Alternating and long-held back-pressure show whether a stalled consumer makes the walk skip rows, which would split or lose runs, or makes the rectangle change under the consumer. Full-repaint and invalid-mode starts, and a start raised in the middle of a walk, expose a design that walks when it should not, emits a spurious rectangle, or pulses done twice.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    // Walk controller phases
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;

    // What the run tracker does with the current cycle
    typedef enum logic [2:0] {
        ACT_NONE  = 3'd0,
        ACT_OPEN  = 3'd1,
        ACT_CLOSE = 3'd2,
        ACT_FLUSH = 3'd3,
        ACT_FULL  = 3'd4
    } run_act_e;

    function automatic logic act_emits(run_act_e a);
        return (a == ACT_CLOSE) || (a == ACT_FLUSH) || (a == ACT_FULL);
    endfunction

endpackage

// File: rtl/dsr_sequencer.sv
module dsr_sequencer
    import dsr_pkg::*;
#(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             full_i,
    input  logic             mode_ok_i,
    input  logic [ROW_W-1:0] height_i,
    input  logic             slot_free_i,
    input  logic             run_open_i,
    input  logic             out_valid_i,
    output logic [ROW_W-1:0] row_o,
    output logic [ROW_W-1:0] hgt_o,
    output logic             accept_o,
    output logic             step_o,
    output logic             full_go_o,
    output logic             flush_go_o,
    output logic             busy_o,
    output logic             done_o
);

    seq_state_e       state_q;
    logic [ROW_W-1:0] row_q;
    logic [ROW_W-1:0] hgt_q;
    logic             done_q;
    logic             bad_mode;
    logic             scan_go;
    logic             finish;
    logic             last_row;

    always_comb begin
        accept_o   = (state_q == ST_IDLE) && start_i;
        bad_mode   = !mode_ok_i || (height_i == '0);
        full_go_o  = accept_o && !bad_mode && full_i;
        scan_go    = accept_o && !bad_mode && !full_i;
        step_o     = (state_q == ST_SCAN) && slot_free_i;
        last_row   = (row_q == hgt_q - ROW_W'(1));
        flush_go_o = (state_q == ST_DRAIN) && run_open_i && slot_free_i;
        finish     = (state_q == ST_DRAIN) && !run_open_i && !out_valid_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
            hgt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= finish;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept_o) begin
                        hgt_q   <= height_i;
                        row_q   <= '0;
                        state_q <= scan_go ? ST_SCAN : ST_DRAIN;
                    end
                end
                ST_SCAN: begin
                    if (step_o) begin
                        row_q <= row_q + ROW_W'(1);
                        if (last_row) begin
                            state_q <= ST_DRAIN;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (finish) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign row_o  = row_q;
    assign hgt_o  = hgt_q;
    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;

    // The walk holds its row while the output slot is occupied
    assert_row_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN && !slot_free_i) |=> $stable(row_q));

    // Only rows inside the frame are visited
    assert_row_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN) |-> (row_q < hgt_q));

    // Completion is a lone pulse, never alongside a pending rectangle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    assert_done_after_out_R8: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !out_valid_i);

    // A busy walk keeps its frame height whatever start_i does
    assert_busy_keeps_frame_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(hgt_q));

endmodule

// File: rtl/dsr_run_tracker.sv
module dsr_run_tracker
    import dsr_pkg::*;
#(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic             dirty_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [ROW_W-1:0] hgt_i,
    input  logic             full_go_i,
    input  logic [ROW_W-1:0] height_in_i,
    input  logic             flush_go_i,
    input  logic             slot_free_i,
    output logic             open_o,
    output logic             emit_o,
    output logic [ROW_W-1:0] emit_y_o,
    output logic [ROW_W-1:0] emit_h_o
);

    run_act_e         act;
    logic             open_q;
    logic [ROW_W-1:0] start_q;

    always_comb begin
        act = ACT_NONE;
        if (full_go_i) begin
            act = ACT_FULL;
        end else if (step_i) begin
            if (dirty_i && !open_q) begin
                act = ACT_OPEN;
            end else if (!dirty_i && open_q) begin
                act = ACT_CLOSE;
            end
        end else if (flush_go_i) begin
            act = ACT_FLUSH;
        end
    end

    always_comb begin
        emit_o   = act_emits(act);
        emit_y_o = start_q;
        emit_h_o = '0;
        unique case (act)
            ACT_CLOSE: emit_h_o = row_i - start_q;
            ACT_FLUSH: emit_h_o = hgt_i - start_q;
            ACT_FULL: begin
                emit_y_o = '0;
                emit_h_o = height_in_i;
            end
            default: emit_h_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            start_q <= '0;
        end else begin
            unique case (act)
                ACT_OPEN: begin
                    open_q  <= 1'b1;
                    start_q <= row_i;
                end
                ACT_CLOSE, ACT_FLUSH: open_q <= 1'b0;
                default: ;
            endcase
        end
    end

    assign open_o = open_q;

    // Runs are never empty
    assert_run_nonempty_R2: assert property (@(posedge clk) disable iff (rst)
        emit_o |-> (emit_h_o != '0));

    // A rectangle is only produced into a free output slot
    assert_emit_free_slot_R7: assert property (@(posedge clk) disable iff (rst)
        emit_o |-> slot_free_i);

endmodule

// File: rtl/dsr_region_reg.sv
module dsr_region_reg #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [ROW_W-1:0] ld_y_i,
    input  logic [ROW_W-1:0] ld_h_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [ROW_W-1:0] y_o,
    output logic [ROW_W-1:0] h_o
);

    logic             valid_q;
    logic [ROW_W-1:0] y_q;
    logic [ROW_W-1:0] h_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            y_q     <= '0;
            h_q     <= '0;
        end else if (load_i) begin
            valid_q <= 1'b1;
            y_q     <= ld_y_i;
            h_q     <= ld_h_i;
        end else if (ready_i) begin
            valid_q <= 1'b0;
        end
    end

    assign valid_o = valid_q;
    assign y_o     = y_q;
    assign h_o     = h_q;

    // A stalled rectangle stays put until taken
    assert_hold_stalled_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !ready_i) |=> (valid_q && $stable(y_q) && $stable(h_q)));

endmodule

// File: rtl/dirty_run_coalescer.sv
module dirty_run_coalescer #(
    parameter int ROW_W = 12,
    parameter int COL_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             full_i,
    input  logic             mode_ok_i,
    input  logic [ROW_W-1:0] height_i,
    input  logic [COL_W-1:0] width_i,
    output logic [ROW_W-1:0] scan_row_o,
    input  logic             dirty_i,
    output logic             rgn_valid_o,
    input  logic             rgn_ready_i,
    output logic [COL_W-1:0] rgn_x_o,
    output logic [ROW_W-1:0] rgn_y_o,
    output logic [COL_W-1:0] rgn_w_o,
    output logic [ROW_W-1:0] rgn_h_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam int SUM_W = ROW_W + 1;

    logic             slot_free;
    logic             run_open;
    logic             accept;
    logic             step;
    logic             full_go;
    logic             flush_go;
    logic [ROW_W-1:0] hgt;
    logic             emit;
    logic [ROW_W-1:0] emit_y;
    logic [ROW_W-1:0] emit_h;
    logic [COL_W-1:0] width_q;

    assign slot_free = !rgn_valid_o || rgn_ready_i;

    dsr_sequencer #(.ROW_W(ROW_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .full_i     (full_i),
        .mode_ok_i  (mode_ok_i),
        .height_i   (height_i),
        .slot_free_i(slot_free),
        .run_open_i (run_open),
        .out_valid_i(rgn_valid_o),
        .row_o      (scan_row_o),
        .hgt_o      (hgt),
        .accept_o   (accept),
        .step_o     (step),
        .full_go_o  (full_go),
        .flush_go_o (flush_go),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    dsr_run_tracker #(.ROW_W(ROW_W)) u_trk (
        .clk        (clk),
        .rst        (rst),
        .step_i     (step),
        .dirty_i    (dirty_i),
        .row_i      (scan_row_o),
        .hgt_i      (hgt),
        .full_go_i  (full_go),
        .height_in_i(height_i),
        .flush_go_i (flush_go),
        .slot_free_i(slot_free),
        .open_o     (run_open),
        .emit_o     (emit),
        .emit_y_o   (emit_y),
        .emit_h_o   (emit_h)
    );

    dsr_region_reg #(.ROW_W(ROW_W)) u_out (
        .clk    (clk),
        .rst    (rst),
        .load_i (emit),
        .ld_y_i (emit_y),
        .ld_h_i (emit_h),
        .ready_i(rgn_ready_i),
        .valid_o(rgn_valid_o),
        .y_o    (rgn_y_o),
        .h_o    (rgn_h_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            width_q <= '0;
        end else if (accept) begin
            width_q <= width_i;
        end
    end

    assign rgn_x_o = '0;
    assign rgn_w_o = width_q;

    // Every rectangle lies inside the frame that was latched at start
    assert_rect_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
        rgn_valid_o |-> ((SUM_W'(rgn_y_o) + SUM_W'(rgn_h_o)) <= SUM_W'(hgt)));

    // Width cannot change under a pending rectangle
    assert_width_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (rgn_valid_o && !rgn_ready_i) |=> $stable(rgn_w_o));

endmodule

// File: tb/dirty_run_coalescer_bench.sv
module dirty_run_coalescer_bench;

    localparam int ROW_W = 12;
    localparam int COL_W = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic             full_i = 1'b0;
    logic             mode_ok_i = 1'b1;
    logic [ROW_W-1:0] height_i = '0;
    logic [COL_W-1:0] width_i = '0;
    logic [ROW_W-1:0] scan_row_o;
    logic             dirty_i;
    logic             rgn_valid_o;
    logic             rgn_ready_i = 1'b1;
    logic [COL_W-1:0] rgn_x_o;
    logic [ROW_W-1:0] rgn_y_o;
    logic [COL_W-1:0] rgn_w_o;
    logic [ROW_W-1:0] rgn_h_o;
    logic             busy_o;
    logic             done_o;

    logic [15:0] cur_mask = '0;
    int tests = 0;
    int fails = 0;
    int cyc = 0;

    int got_n;
    int got_done;
    int got_y [8];
    int got_h [8];

    always #10 clk = ~clk;   // 50 MHz

    assign dirty_i = (scan_row_o < 16) ? cur_mask[scan_row_o[3:0]] : 1'b0;

    dirty_run_coalescer #(.ROW_W(ROW_W), .COL_W(COL_W)) u_dirty_run_coalescer (
        .clk(clk), .rst(rst), .start_i(start_i), .full_i(full_i),
        .mode_ok_i(mode_ok_i), .height_i(height_i), .width_i(width_i),
        .scan_row_o(scan_row_o), .dirty_i(dirty_i),
        .rgn_valid_o(rgn_valid_o), .rgn_ready_i(rgn_ready_i),
        .rgn_x_o(rgn_x_o), .rgn_y_o(rgn_y_o), .rgn_w_o(rgn_w_o),
        .rgn_h_o(rgn_h_o), .busy_o(busy_o), .done_o(done_o)
    );

    // tag, height, dirty mask, full, mode ok, expected count, rectangles
    // rectangle k sits in bits [k*16 +: 16] as {top row[15:8], count[7:0]}
    typedef struct packed {
        logic [3:0]  tag;
        logic [4:0]  hgt;
        logic [15:0] mask;
        logic        full;
        logic        ok;
        logic [2:0]  n;
        logic [63:0] rg;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 5'd8,  16'h0000, 1'b0, 1'b1, 3'd0, 64'h0},                   // R2 all clean
        '{4'd2, 5'd8,  16'h0036, 1'b0, 1'b1, 3'd2, 64'h0000_0000_0402_0102}, // R2 two runs
        '{4'd3, 5'd8,  16'h00FF, 1'b0, 1'b1, 3'd1, 64'h0000_0000_0000_0008}, // R3 whole frame flushed
        '{4'd3, 5'd8,  16'h0081, 1'b0, 1'b1, 3'd2, 64'h0000_0000_0701_0001}, // R3 first and last row
        '{4'd3, 5'd16, 16'hF0F0, 1'b0, 1'b1, 3'd2, 64'h0000_0000_0C04_0404}, // R3 bottom run
        '{4'd2, 5'd8,  16'h0055, 1'b0, 1'b1, 3'd4, 64'h0601_0401_0201_0001}, // R2 single rows
        '{4'd4, 5'd8,  16'h0055, 1'b1, 1'b1, 3'd1, 64'h0000_0000_0000_0008}, // R4 full repaint
        '{4'd4, 5'd16, 16'h0000, 1'b1, 1'b1, 3'd1, 64'h0000_0000_0000_0010}, // R4 full, clean store
        '{4'd6, 5'd8,  16'h00FF, 1'b0, 1'b0, 3'd0, 64'h0},                   // R6 invalid mode
        '{4'd6, 5'd0,  16'hFFFF, 1'b0, 1'b1, 3'd0, 64'h0},                   // R6 zero height
        '{4'd6, 5'd8,  16'h00FF, 1'b1, 1'b0, 3'd0, 64'h0},                   // R6 invalid beats full
        '{4'd3, 5'd1,  16'h0001, 1'b0, 1'b1, 3'd1, 64'h0000_0000_0000_0001}, // R3 one-row frame
        '{4'd2, 5'd12, 16'hFFFF, 1'b0, 1'b1, 3'd1, 64'h0000_0000_0000_000C}, // R2 rows past height unseen
        '{4'd2, 5'd16, 16'h7FFE, 1'b0, 1'b1, 3'd1, 64'h0000_0000_0000_010E}  // R2 closed by last row
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    // Collect rectangles until done, sampling at falling edges.
    task automatic collect(input bit stall, input int width, input string req);
        int k;
        k = 0;
        got_n = 0;
        got_done = 0;
        for (int t = 0; t < 2000; t++) begin
            rgn_ready_i = stall ? k[0] : 1'b1;
            k++;
            if (rgn_valid_o && rgn_ready_i) begin
                if (got_n < 8) begin
                    got_y[got_n] = int'(rgn_y_o);
                    got_h[got_n] = int'(rgn_h_o);
                end
                got_n++;
                chk(rgn_x_o == '0, "R5 x", int'(rgn_x_o), 0);
                chk(int'(rgn_w_o) == width, "R5 width", int'(rgn_w_o), width);
            end
            if (done_o) begin
                got_done = 1;
                chk(!rgn_valid_o, "R8 done with pending rectangle", int'(rgn_valid_o), 0);
                break;
            end
            @(negedge clk);
        end
        chk(got_done == 1, {req, " done seen"}, got_done, 1);
        @(negedge clk);
        chk(!done_o, "R8 done single pulse", int'(done_o), 0);
        chk(!busy_o, "R8 idle after done", int'(busy_o), 0);
        rgn_ready_i = 1'b1;
    endtask

    task automatic launch(input int h, input logic [15:0] m, input bit f,
                          input bit ok, input int w);
        @(negedge clk);
        height_i  = ROW_W'(h);
        cur_mask  = m;
        full_i    = f;
        mode_ok_i = ok;
        width_i   = COL_W'(w);
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
        full_i    = 1'b0;
    endtask

    initial begin
        string req;
        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!rgn_valid_o, "R1 valid", int'(rgn_valid_o), 0);
        chk(!busy_o, "R1 busy", int'(busy_o), 0);
        chk(!done_o, "R1 done", int'(done_o), 0);

        // Table walk; odd entries get alternating back-pressure (R7)
        for (int i = 0; i < NV; i++) begin
            req = $sformatf("R%0d vec%0d", VECS[i].tag, i);
            launch(int'(VECS[i].hgt), VECS[i].mask, VECS[i].full, VECS[i].ok, 100 + i);
            collect(i[0], 100 + i, req);
            chk(got_n == int'(VECS[i].n), {req, " count"}, got_n, int'(VECS[i].n));
            for (int r = 0; r < int'(VECS[i].n) && r < got_n; r++) begin
                chk(got_y[r] == int'(VECS[i].rg[r*16+8 +: 8]), {req, " top row"},
                    got_y[r], int'(VECS[i].rg[r*16+8 +: 8]));
                chk(got_h[r] == int'(VECS[i].rg[r*16 +: 8]), {req, " row count"},
                    got_h[r], int'(VECS[i].rg[r*16 +: 8]));
            end
        end

        // R7 long stall, with R9 ignored start in the middle
        rgn_ready_i = 1'b0;
        launch(8, 16'h0036, 1'b0, 1'b1, 321);
        rgn_ready_i = 1'b0;
        repeat (6) @(negedge clk);
        chk(rgn_valid_o, "R7 held valid", int'(rgn_valid_o), 1);
        chk(rgn_y_o == 1, "R7 held top row", int'(rgn_y_o), 1);
        chk(rgn_h_o == 2, "R7 held count", int'(rgn_h_o), 2);
        height_i  = 16;
        width_i   = 77;
        full_i    = 1'b1;
        cur_mask  = 16'h0036;
        start_i   = 1'b1;          // R9: must be ignored
        @(negedge clk);
        start_i   = 1'b0;
        full_i    = 1'b0;
        repeat (6) @(negedge clk);
        chk(rgn_y_o == 1 && rgn_h_o == 2, "R7 still held", int'(rgn_h_o), 2);
        chk(busy_o, "R9 still busy", int'(busy_o), 1);
        collect(1'b0, 321, "R9 stalled walk");
        chk(got_n == 2, "R9 count", got_n, 2);
        chk(got_n == 2 && got_y[1] == 4 && got_h[1] == 2, "R7 second run intact",
            got_h[1], 2);
        repeat (10) begin
            chk(!rgn_valid_o && !done_o, "R9 no second walk", int'(rgn_valid_o), 0);
            @(negedge clk);
        end

        finish_run();
    end

endmodule